// File: doc/BRIEF.md
# Triggered Pulse Delay Sweeper

This block runs a series of timed trials against a device under test. In each trial it waits for a rising edge on an external digital trigger line, counts a programmable number of clock cycles, and then drives a pulse for a programmable number of cycles. During the pulse the output is enabled; outside it the output is released to its idle, undriven state. When the pulse ends, the block raises a reset strobe toward the target for a fixed number of cycles. It then waits a programmable settle time and re-arms for the next trigger.

Across trials the block sweeps two settings automatically. Delay is the outer loop and width is the inner loop, so every width value is tried for each delay value. Each loop starts at its lower bound, adds its step after each pass, and ends once the next value would pass its upper bound. Both settings count single clock cycles, so timing resolution is one clock period. The delay and width currently in use are presented on outputs, and a done flag reports the end of the sweep. A start command loads the bounds and begins a new sweep.

Top module: `trig_pulse_sweeper`

## Requirements
- R1: The trigger input passes through a SYNC_STAGES-flop synchroniser (2 by default) and then a rising-edge detector. If `trig_in` is first sampled high at clock edge k during an armed trial, `pulse_en` is high after edges k+2+D up to and including k+1+D+W, where D is `cur_dly` and W is `cur_wid`.
- R2: `drive_oe` is high in exactly the same cycles as `pulse_en`. Both are low at all other times.
- R3: `tgt_rst` goes high at the edge where the pulse ends and stays high for exactly RST_LEN cycles (16 by default). It is never high together with `pulse_en`.
- R4: With W = 0 no pulse is produced. `tgt_rst` still rises, at edge k+2+D, and the trial completes normally.
- R5: After `tgt_rst` falls, the block waits `settle_cyc` cycles (0 means none) before it re-arms. A trigger that arrives after re-arming starts the next trial.
- R6: Trigger rising edges that arrive while a trial is in progress (delay, pulse, reset or settle) are ignored. They neither restart nor extend the trial.
- R7: The sweep order is delay outer and width inner. Width reloads its lower bound whenever delay steps. A loop ends when its current value plus its step is greater than its upper bound.
- R8: A step value of 0 makes its loop run a single pass, at the lower bound only.
- R9: `done` rises at the edge where the last trial's settle time ends. While `done` is high, triggers produce no pulse and no reset strobe.
- R10: `start` is accepted only while the block is idle, either after reset or after `done`. It clears `done`, sets `cur_dly` and `cur_wid` to their lower bounds at the same edge, and latches all bounds and steps for the whole sweep. While a sweep is running, `start` is ignored.
- R11: `cur_dly` and `cur_wid` change only at the edge where the block re-arms. They hold their values from the trigger detection to the end of settle. After the last trial they keep that trial's values.
- R12: While reset is active and after it is released, `pulse_en`, `drive_oe`, `tgt_rst`, `done`, `cur_dly` and `cur_wid` are all 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line from the target |
| start | input | 1 | Starts a new sweep when idle |
| dly_lo | input | CNT_W | Delay lower bound |
| dly_hi | input | CNT_W | Delay upper bound |
| dly_inc | input | CNT_W | Delay step |
| wid_lo | input | CNT_W | Width lower bound |
| wid_hi | input | CNT_W | Width upper bound |
| wid_inc | input | CNT_W | Width step |
| settle_cyc | input | SETTLE_W | Wait after the target reset before re-arming |
| pulse_en | output | 1 | Pulse active |
| drive_oe | output | 1 | Output enable; low means undriven |
| tgt_rst | output | 1 | Reset strobe toward the target |
| cur_dly | output | CNT_W | Delay of the current trial |
| cur_wid | output | CNT_W | Width of the current trial |
| done | output | 1 | Sweep finished |

## Verification
The bench builds the block with CNT_W = 10, SETTLE_W = 8 and the default RST_LEN of 16. These values keep every trial to a few dozen cycles, so complete sweeps fit into a short run. The first sweep covers zero delay, zero width, an upper bound that the width step does not land on exactly, and a non-zero settle time. The second sweep, started after `done`, uses a zero delay step and no settle time. It also changes a bound input during the run and pulses `start` in mid-trial, while extra trigger edges are injected inside every trial.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DELAY,
    ST_PULSE,
    ST_RESET,
    ST_SETTLE
  } tps_state_e;
endpackage

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R1: a detected edge lasts a single cycle
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tps_sweep_step.sv
module tps_sweep_step #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] dly_lo,
  input  logic [CNT_W-1:0] dly_hi,
  input  logic [CNT_W-1:0] dly_inc,
  input  logic [CNT_W-1:0] wid_lo,
  input  logic [CNT_W-1:0] wid_hi,
  input  logic [CNT_W-1:0] wid_inc,
  output logic [CNT_W-1:0] cur_dly,
  output logic [CNT_W-1:0] cur_wid,
  output logic             done,
  output logic             last
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] d_hi_q, d_inc_q, w_lo_q, w_hi_q, w_inc_q;
  logic [SUM_W-1:0] d_sum, w_sum;
  logic             d_end, w_end;

  assign d_sum = {1'b0, cur_dly} + {1'b0, d_inc_q};
  assign w_sum = {1'b0, cur_wid} + {1'b0, w_inc_q};
  assign d_end = (d_inc_q == '0) || (d_sum > {1'b0, d_hi_q});
  assign w_end = (w_inc_q == '0) || (w_sum > {1'b0, w_hi_q});
  assign last  = d_end && w_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_dly <= '0;
      cur_wid <= '0;
      done    <= 1'b0;
      d_hi_q  <= '0;
      d_inc_q <= '0;
      w_lo_q  <= '0;
      w_hi_q  <= '0;
      w_inc_q <= '0;
    end else if (load) begin
      cur_dly <= dly_lo;
      cur_wid <= wid_lo;
      done    <= 1'b0;
      d_hi_q  <= dly_hi;
      d_inc_q <= dly_inc;
      w_lo_q  <= wid_lo;
      w_hi_q  <= wid_hi;
      w_inc_q <= wid_inc;
    end else if (adv) begin
      if (!w_end) begin
        cur_wid <= w_sum[CNT_W-1:0];
      end else if (!d_end) begin
        cur_wid <= w_lo_q;
        cur_dly <= d_sum[CNT_W-1:0];
      end else begin
        done <= 1'b1;
      end
    end
  end

  // R9: done only rises when a trial has just been closed
  assert_done_on_adv_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(adv));
  // R10: a load always leaves the sweep not done
  assert_load_clears_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> !done);
endmodule

// File: rtl/tps_trial_seq.sv
module tps_trial_seq
  import tps_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SETTLE_W = 16,
  parameter int RST_LEN  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                rise,
  input  logic [CNT_W-1:0]    cur_dly,
  input  logic [CNT_W-1:0]    cur_wid,
  input  logic [SETTLE_W-1:0] settle_cyc,
  input  logic                last,
  output logic                load,
  output logic                adv,
  output logic                pulse_en,
  output logic                drive_oe,
  output logic                tgt_rst,
  output tps_state_e          state
);
  localparam int RST_W = $clog2(RST_LEN + 1);
  localparam int MX_A  = (CNT_W > SETTLE_W) ? CNT_W : SETTLE_W;
  localparam int CW    = (MX_A > RST_W) ? MX_A : RST_W;

  logic [CW-1:0] cnt;
  tps_state_e    fire_state;
  logic [CW-1:0] fire_cnt;
  logic          fire_pulse;
  logic          reset_done, settle_done;

  // values taken when the delay has expired
  always_comb begin
    if (cur_wid == '0) begin
      fire_state = ST_RESET;
      fire_cnt   = CW'(RST_LEN - 1);
      fire_pulse = 1'b0;
    end else begin
      fire_state = ST_PULSE;
      fire_cnt   = CW'(cur_wid) - CW'(1);
      fire_pulse = 1'b1;
    end
  end

  assign reset_done  = (state == ST_RESET) && (cnt == '0);
  assign settle_done = (state == ST_SETTLE) && (cnt == '0);
  assign load = (state == ST_IDLE) && start;
  assign adv  = (reset_done && (settle_cyc == '0)) || settle_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pulse_en <= 1'b0;
      drive_oe <= 1'b0;
      tgt_rst  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_ARM;
        end
        ST_ARM: begin
          if (rise) begin
            if (cur_dly == '0) begin
              state    <= fire_state;
              cnt      <= fire_cnt;
              pulse_en <= fire_pulse;
              drive_oe <= fire_pulse;
              tgt_rst  <= ~fire_pulse;
            end else begin
              state <= ST_DELAY;
              cnt   <= CW'(cur_dly) - CW'(1);
            end
          end
        end
        ST_DELAY: begin
          if (cnt == '0) begin
            state    <= fire_state;
            cnt      <= fire_cnt;
            pulse_en <= fire_pulse;
            drive_oe <= fire_pulse;
            tgt_rst  <= ~fire_pulse;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            state    <= ST_RESET;
            cnt      <= CW'(RST_LEN - 1);
            pulse_en <= 1'b0;
            drive_oe <= 1'b0;
            tgt_rst  <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_RESET: begin
          if (cnt == '0) begin
            tgt_rst <= 1'b0;
            if (settle_cyc == '0) begin
              state <= last ? ST_IDLE : ST_ARM;
            end else begin
              state <= ST_SETTLE;
              cnt   <= CW'(settle_cyc) - CW'(1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) state <= last ? ST_IDLE : ST_ARM;
          else           cnt <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: pulse and target reset never overlap
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(pulse_en && tgt_rst));
  // R3: the end of a pulse is followed straight away by the target reset
  assert_rst_follows_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_en) |-> tgt_rst);
  // R4: a pulse only starts for a non-zero width
  assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_en) |-> (cur_wid != '0));
  // R2: the enable tracks the pulse
  assert_oe_track_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_en) |-> $rose(drive_oe));
endmodule

// File: rtl/trig_pulse_sweeper.sv
module trig_pulse_sweeper
  import tps_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SETTLE_W    = 16,
  parameter int RST_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_in,
  input  logic                start,
  input  logic [CNT_W-1:0]    dly_lo,
  input  logic [CNT_W-1:0]    dly_hi,
  input  logic [CNT_W-1:0]    dly_inc,
  input  logic [CNT_W-1:0]    wid_lo,
  input  logic [CNT_W-1:0]    wid_hi,
  input  logic [CNT_W-1:0]    wid_inc,
  input  logic [SETTLE_W-1:0] settle_cyc,
  output logic                pulse_en,
  output logic                drive_oe,
  output logic                tgt_rst,
  output logic [CNT_W-1:0]    cur_dly,
  output logic [CNT_W-1:0]    cur_wid,
  output logic                done
);
  logic       rise, load, adv, last;
  tps_state_e state;

  tps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(trig_in), .rise(rise)
  );

  tps_sweep_step #(.CNT_W(CNT_W)) u_sweep (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .dly_lo(dly_lo), .dly_hi(dly_hi), .dly_inc(dly_inc),
    .wid_lo(wid_lo), .wid_hi(wid_hi), .wid_inc(wid_inc),
    .cur_dly(cur_dly), .cur_wid(cur_wid), .done(done), .last(last)
  );

  tps_trial_seq #(.CNT_W(CNT_W), .SETTLE_W(SETTLE_W), .RST_LEN(RST_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rise(rise),
    .cur_dly(cur_dly), .cur_wid(cur_wid), .settle_cyc(settle_cyc), .last(last),
    .load(load), .adv(adv), .pulse_en(pulse_en), .drive_oe(drive_oe),
    .tgt_rst(tgt_rst), .state(state)
  );

  // R9: a finished sweep leaves the sequencer idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE));
  // R11: settings hold while a trial is under way
  assert_vals_stable_R11: assert property (@(posedge clk) disable iff (rst)
    ((state inside {ST_DELAY, ST_PULSE, ST_RESET}) &&
     ($past(state) inside {ST_DELAY, ST_PULSE, ST_RESET}))
    |-> ($stable(cur_dly) && $stable(cur_wid)));
endmodule

// File: tb/trig_pulse_sweeper_bench.sv
module trig_pulse_sweeper_bench;
  localparam int CW = 10;
  localparam int SW = 8;
  localparam int RL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] dly_lo = '0, dly_hi = '0, dly_inc = '0;
  logic [CW-1:0] wid_lo = '0, wid_hi = '0, wid_inc = '0;
  logic [SW-1:0] settle_cyc = '0;
  logic pulse_en, drive_oe, tgt_rst, done;
  logic [CW-1:0] cur_dly, cur_wid;

  trig_pulse_sweeper #(.CNT_W(CW), .SETTLE_W(SW), .RST_LEN(RL)) u_trig_pulse_sweeper (
    .clk(clk), .rst(rst), .trig_in(trig_in), .start(start),
    .dly_lo(dly_lo), .dly_hi(dly_hi), .dly_inc(dly_inc),
    .wid_lo(wid_lo), .wid_hi(wid_hi), .wid_inc(wid_inc),
    .settle_cyc(settle_cyc), .pulse_en(pulse_en), .drive_oe(drive_oe),
    .tgt_rst(tgt_rst), .cur_dly(cur_dly), .cur_wid(cur_wid), .done(done)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit chk_on = 1'b0;
  // expected windows (edge indices) and value switch point
  int e_plo = 0, e_phi = 0, e_rlo = 0, e_rhi = 0, e_sw = 0;
  int e_d0 = 0, e_w0 = 0, e_dn0 = 0, e_d1 = 0, e_w1 = 0, e_dn1 = 0;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // reference compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      int pe, re;
      pe = (cyc >= e_plo && cyc < e_phi) ? 1 : 0;
      re = (cyc >= e_rlo && cyc < e_rhi) ? 1 : 0;
      check("R1 pulse_en", int'(pulse_en), pe);
      check("R2 drive_oe", int'(drive_oe), pe);
      check("R3 tgt_rst", int'(tgt_rst), re);
      check("R11 cur_dly", int'(cur_dly), (cyc >= e_sw) ? e_d1 : e_d0);
      check("R7 cur_wid", int'(cur_wid), (cyc >= e_sw) ? e_w1 : e_w0);
      check("R9 done", int'(done), (cyc >= e_sw) ? e_dn1 : e_dn0);
    end
  end

  task automatic run_sweep(int dl, int dh, int di, int wl, int wh, int wi,
                           int st, bit disturb);
    int dq[$], wq[$];
    int d, w, a_edge, m;
    d = dl;
    forever begin
      w = wl;
      forever begin
        dq.push_back(d); wq.push_back(w);
        if (wi == 0 || w + wi > wh) break;
        w += wi;
      end
      if (di == 0 || d + di > dh) break;
      d += di;
    end
    dly_lo = CW'(dl); dly_hi = CW'(dh); dly_inc = CW'(di);
    wid_lo = CW'(wl); wid_hi = CW'(wh); wid_inc = CW'(wi);
    settle_cyc = SW'(st);
    @(negedge clk);
    // R10: start loads the lower bounds and clears done at the next edge
    e_d0 = e_d1; e_w0 = e_w1; e_dn0 = e_dn1;
    e_d1 = dl; e_w1 = wl; e_dn1 = 0; e_sw = cyc + 1;
    a_edge = cyc + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: bounds are latched; a changed input must not affect this sweep
    if (disturb) wid_hi = '0;
    for (int i = 0; i < dq.size(); i++) begin
      while (cyc < a_edge + 1) @(negedge clk);
      m = cyc;
      trig_in = 1'b1;
      e_plo = m + 3 + dq[i];          // R1, R4: k = m+1, pulse from k+2+D
      e_phi = e_plo + wq[i];          // R2
      e_rlo = e_phi;                  // R3
      e_rhi = e_rlo + RL;
      a_edge = e_rhi + st;            // R5
      e_sw = a_edge;
      e_d0 = dq[i]; e_w0 = wq[i]; e_dn0 = 0;
      if (i == dq.size() - 1) begin
        e_d1 = dq[i]; e_w1 = wq[i]; e_dn1 = 1;
      end else begin
        e_d1 = dq[i+1]; e_w1 = wq[i+1]; e_dn1 = 0;
      end
      // R6: extra edges inside the trial must be ignored
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
      repeat (2) @(negedge clk);
      if (disturb) start = 1'b1;    // R10: start ignored mid-sweep
      @(negedge clk);
      start = 1'b0;
      trig_in = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
    end
    while (cyc < a_edge + 2) @(negedge clk);
    // R9: trigger after done produces nothing
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 pulse_en", int'(pulse_en), 0);
    check("R12 tgt_rst", int'(tgt_rst), 0);
    check("R12 done", int'(done), 0);
    check("R12 cur_dly", int'(cur_dly), 0);
    rst = 1'b0;
    chk_on = 1'b1;
    repeat (4) @(negedge clk);
    // R12: idle after reset, a trigger before start does nothing
    trig_in = 1'b1;
    repeat (4) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    // R7, R4, R5: delays 0,6,12; widths 0,5 (10 passes bound 7); settle 3
    run_sweep(0, 12, 6, 0, 7, 5, 3, 1'b0);
    // R8, R10: zero delay step, restart from done, no settle, disturbances
    run_sweep(3, 100, 0, 4, 9, 3, 0, 1'b1);
    chk_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule